// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Slave

This block is a slave on a three-wire serial bus made of a serial clock, one data line and a latch strobe. The master sends 25-bit frames. Each frame holds a 4-bit register address, then a direction flag, then a 20-bit data word, and every field goes out lowest bit first. A write frame fills a shift register, and the rising edge of the latch strobe commits that word into one of eleven 20-bit configuration registers. Each register has its own default value after reset. A read frame uses the same data line: once the direction flag has been taken, the slave drives the register contents back. All register contents leave the block on a flat parallel bus, and the synthesizer counter word of register 1 is also given in split form.

The three bus pins are slow and asynchronous to the block. They pass through two-flop synchronizers and are edge-detected on the faster system clock. The data line is split at the pad into an input, an output and an output enable. A mode input selects between serial operation and a static mode. In the static mode the three pins are read as a 3-bit channel code, and any serial traffic on them is ignored.

Top module: `tw_cfg_slave`

## Requirements
- R1: Frame bit k (k = 0..24, counted from the first rising serial clock after the latch was last low) is as follows. Bits 0..3 are address bits 0..3. Bit 4 is the direction flag. Bits 5..24 are data bits 0..19. A direction flag of 1 with 25 clocks, followed by a latch rising edge, writes the data word into the addressed register.
- R2: A direction flag of 0 makes a read frame, and a read frame never changes any register. More generally, the register bank changes only in the cycle after a commit.
- R3: After reset the registers hold these values, by address in hex: 0:00008, 1:02A05, 2:FFE44, 3:03980, 4:7ABEF, 5:7E1D2, 6:82408, 7:82408, 8:0FF80, 9:B2007, A:10C13. Register n occupies cfg_out[20n+19:20n].
- R4: In a read frame, the output enable rises at the first falling serial clock after the direction flag. The 20 data bits are then driven lowest bit first, with one new bit after each falling clock. The enable stays high until the latch rises and is low at every other time.
- R5: A latch rising edge after fewer than 25 serial clocks commits nothing. Serial clocks beyond the 25th are ignored, so the first 25 bits are still committed.
- R6: Writes to addresses 11..15 are discarded, and reads from those addresses return zero.
- R7: While mode_sel is 0, chan_code = {sclk, sle, sdio_in}, serial frames are ignored and the output enable stays low. While mode_sel is 1, chan_code is 0.
- R8: n_count equals bits [19:7] of register 1, and a_count equals bits [6:0] of register 1 (defaults 84 and 5).
- R9: Rising serial clocks seen while the latch is high are ignored, including one in the same cycle as the latch rising edge. The next frame starts again at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | 1 = serial mode, 0 = channel-code mode |
| sclk | input | 1 | Serial clock |
| sle | input | 1 | Latch strobe |
| sdio_in | input | 1 | Data line, input side |
| sdio_out | output | 1 | Data line, output side |
| sdio_oe | output | 1 | Data line output enable |
| chan_code | output | 3 | Static channel code in channel-code mode |
| cfg_out | output | 220 | All registers, register n at [20n+19:20n] |
| n_count | output | 13 | N counter field of register 1 |
| a_count | output | 7 | A counter field of register 1 |

## Verification
The latch rising edge and a rising serial clock can be detected in the same system cycle. The latch must win: it commits the full frame and clears the bit counter, and the clock edge must not shift in a bit. The bench provokes this by raising an extra serial clock and the latch on the same system edge after a full write frame. It judges the outcome in two ways: the register must hold the written word, and the frame that follows, to another address, must land correctly, which shows that the counter restarted at bit 0.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
  localparam int DATA_W = 20;
  localparam int ADDR_W = 4;
  localparam int REG_N  = 11;
  localparam int FRAME_LEN = ADDR_W + 1 + DATA_W;
  localparam int N_W = 13;
  localparam int A_W = 7;

  // reset value of each configuration register
  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    case (idx)
      0:  return 20'h00008;
      1:  return 20'h02A05;
      2:  return 20'hFFE44;
      3:  return 20'h03980;
      4:  return 20'h7ABEF;
      5:  return 20'h7E1D2;
      6:  return 20'h82408;
      7:  return 20'h82408;
      8:  return 20'h0FF80;
      9:  return 20'hB2007;
      10: return 20'h10C13;
      default: return '0;
    endcase
  endfunction

  function automatic logic [N_W-1:0] n_field(input logic [DATA_W-1:0] w);
    return w[DATA_W-1 -: N_W];
  endfunction

  function automatic logic [A_W-1:0] a_field(input logic [DATA_W-1:0] w);
    return w[A_W-1:0];
  endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;
  logic [W-1:0] stab;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i] <= 1'b0;
        stab[i] <= 1'b0;
      end else begin
        meta[i] <= din[i];
        stab[i] <= meta[i];
      end
    end
  end

  assign dout = stab;
endmodule

// File: rtl/tw_frame.sv
module tw_frame #(
  parameter int DW = 20,
  parameter int AW = 4,
  localparam int FL = AW + 1 + DW,
  localparam int CW = $clog2(FL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sclk_q,
  input  logic          le_q,
  input  logic          sd_q,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic [DW-1:0] wdata,
  output logic          sd_out,
  output logic          sd_oe,
  output logic          sclk_rise,
  output logic          sclk_fall,
  output logic          le_rise,
  output logic [CW-1:0] bit_cnt
);
  localparam logic [CW-1:0] FULL = CW'(FL);
  localparam logic [CW-1:0] RW_DONE = CW'(AW + 1);

  logic          sclk_d, le_d, rw;
  logic [DW-1:0] shin, shout;

  assign sclk_rise = sclk_q & ~sclk_d;
  assign sclk_fall = ~sclk_q & sclk_d;
  assign le_rise   = le_q & ~le_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      le_d    <= 1'b0;
      bit_cnt <= '0;
      addr    <= '0;
      rw      <= 1'b0;
      shin    <= '0;
      shout   <= '0;
      sd_oe   <= 1'b0;
    end else begin
      sclk_d <= sclk_q;
      le_d   <= le_q;
      if (!en || le_rise) begin
        bit_cnt <= '0;
        sd_oe   <= 1'b0;
      end else begin
        if (sclk_rise && !le_q && bit_cnt < FULL) begin
          if (bit_cnt < CW'(AW))       addr <= {sd_q, addr[AW-1:1]};
          else if (bit_cnt == CW'(AW)) rw   <= sd_q;
          else                         shin <= {sd_q, shin[DW-1:1]};
          bit_cnt <= bit_cnt + CW'(1);
        end
        if (sclk_fall && !le_q && bit_cnt >= RW_DONE && !rw) begin
          if (!sd_oe) begin
            shout <= rd_word;
            sd_oe <= 1'b1;
          end else begin
            shout <= {1'b0, shout[DW-1:1]};
          end
        end
      end
    end
  end

  assign we     = en && le_rise && rw && (bit_cnt == FULL);
  assign wdata  = shin;
  assign sd_out = sd_oe & shout[0];
endmodule

// File: rtl/tw_regbank.sv
module tw_regbank
  import tw_cfg_pkg::*;
#(
  parameter int DW = 20,
  parameter int AW = 4,
  parameter int NREG = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic [NREG*DW-1:0] q_flat
);
  logic [DW-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] RST = DW'(reg_default(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q[i] <= RST;
      else if (we && addr == AW'(i))     q[i] <= wdata;
    end
    assign q_flat[i*DW +: DW] = q[i];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (addr == AW'(i)) rdata = q[i];
  end
endmodule

// File: rtl/tw_cfg_slave.sv
module tw_cfg_slave
  import tw_cfg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NREG = REG_N,
  localparam int CW = $clog2(AW + 1 + DW + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_sel,
  input  logic               sclk,
  input  logic               sle,
  input  logic               sdio_in,
  output logic               sdio_out,
  output logic               sdio_oe,
  output logic [2:0]         chan_code,
  output logic [NREG*DW-1:0] cfg_out,
  output logic [N_W-1:0]     n_count,
  output logic [A_W-1:0]     a_count
);
  logic [3:0]    pins_q;
  logic          mode_q, sclk_q, le_q, sd_q;
  logic          sclk_rise, sclk_fall, le_rise, commit_we;
  logic [CW-1:0] bit_cnt;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_wdata, rd_word;

  tw_sync #(.W(4)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({mode_sel, sclk, sle, sdio_in}),
    .dout(pins_q)
  );
  assign {mode_q, sclk_q, le_q, sd_q} = pins_q;

  tw_frame #(.DW(DW), .AW(AW)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(mode_q),
    .sclk_q(sclk_q), .le_q(le_q), .sd_q(sd_q),
    .rd_word(rd_word), .addr(f_addr), .we(commit_we), .wdata(f_wdata),
    .sd_out(sdio_out), .sd_oe(sdio_oe),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .le_rise(le_rise),
    .bit_cnt(bit_cnt)
  );

  tw_regbank #(.DW(DW), .AW(AW), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(commit_we), .addr(f_addr),
    .wdata(f_wdata), .rdata(rd_word), .q_flat(cfg_out)
  );

  assign chan_code = mode_q ? 3'b000 : {sclk_q, le_q, sd_q};
  assign n_count   = n_field(cfg_out[DW +: DW]);
  assign a_count   = a_field(cfg_out[DW +: DW]);
endmodule

// File: rtl/tw_cfg_slave_chk.sv
module tw_cfg_slave_chk #(
  parameter int W = 220,
  parameter int CW = 5,
  parameter int FL = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_q,
  input logic          sdio_oe,
  input logic          le_rise,
  input logic          sclk_fall,
  input logic          commit_we,
  input logic [CW-1:0] bit_cnt,
  input logic [W-1:0]  cfg_out
);
  assert_oe_static_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !$past(mode_q)) |-> !sdio_oe);

  assert_latch_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise |=> (!sdio_oe && bit_cnt == '0));

  assert_oe_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> $past(sclk_fall));

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(FL));

  assert_bank_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_we |=> $stable(cfg_out));
endmodule

bind tw_cfg_slave tw_cfg_slave_chk #(
  .W(NREG*DW), .CW(CW), .FL(AW + 1 + DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .sdio_oe(sdio_oe),
  .le_rise(le_rise), .sclk_fall(sclk_fall), .commit_we(commit_we),
  .bit_cnt(bit_cnt), .cfg_out(cfg_out)
);

// File: tb/tw_cfg_slave_test.sv
module tw_cfg_slave_test;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0, mode_sel = 1, sclk = 0, sle = 0, sdio_in = 0;
  logic sdio_out, sdio_oe;
  logic [2:0] chan_code;
  logic [219:0] cfg_out;
  logic [12:0] n_count;
  logic [6:0] a_count;
  int runs = 0, fails = 0;
  bit done = 0;
  logic [19:0] model [16];

  always #2.5 clk = ~clk;

  tw_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sclk(sclk), .sle(sle),
    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
    .chan_code(chan_code), .cfg_out(cfg_out), .n_count(n_count), .a_count(a_count)
  );

  function automatic logic [19:0] dflt(input int a);
    logic [19:0] t [11] = '{20'h00008, 20'h02A05, 20'hFFE44, 20'h03980,
      20'h7ABEF, 20'h7E1D2, 20'h82408, 20'h82408, 20'h0FF80, 20'hB2007, 20'h10C13};
    return (a < 11) ? t[a] : 20'h0;
  endfunction

  function automatic logic [19:0] pat(input int a, input int salt);
    return 20'(((a + 1) * 32'h0B6D3 + salt * 32'h31) ^ 32'h5A5A5);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [19:0] reg_of(input int a);
    return cfg_out[a*20 +: 20];
  endfunction

  // frame bit k: 0..3 address, 4 direction, 5..24 data, all lsb first
  task automatic frame(input int a, input bit wr, input logic [19:0] d, input int nclk,
                       input bit le_with_clk, output logic [19:0] rd, output bit oe_ok);
    logic [24:0] w = {d, wr, 4'(a)};
    rd = '0;
    oe_ok = 1;
    sle = 0;
    cyc(HALF);
    for (int k = 0; k < nclk; k++) begin
      sdio_in = (k < 25) ? w[k] : 1'b0;
      cyc(HALF);
      if (k < 5 && sdio_oe) oe_ok = 0;
      if (k >= 5 && k < 25) begin
        if (!wr && !sdio_oe) oe_ok = 0;
        rd[k-5] = sdio_out;
      end
      sclk = 1;
      cyc(HALF);
      sclk = 0;
    end
    cyc(HALF);
    if (le_with_clk) sclk = 1;
    sle = 1;
    cyc(HALF);
    if (sdio_oe) oe_ok = 0;
    sclk = 0;
    sle = 0;
    cyc(HALF);
  endtask

  task automatic wr_reg(input int a, input logic [19:0] d);
    logic [19:0] r; bit o;
    frame(a, 1, d, 25, 0, r, o);
    if (a < 11) model[a] = d;
  endtask

  task automatic rd_reg(input int a, output logic [19:0] r, output bit o);
    frame(a, 0, 20'hFFFFF, 25, 0, r, o);
  endtask

  initial begin
    logic [19:0] r;
    bit o;
    for (int i = 0; i < 16; i++) model[i] = dflt(i);
    cyc(4);
    rst_n = 1;
    cyc(4);
    // R3 reset defaults on the parallel bus
    for (int a = 0; a < 11; a++) chk(reg_of(a) == dflt(a), "R3 default", reg_of(a), dflt(a));
    // R8 split of register 1
    chk(n_count == 13'd84, "R8 n default", n_count, 84);
    chk(a_count == 7'd5, "R8 a default", a_count, 5);
    chk(chan_code == 3'b000, "R7 serial-mode code", chan_code, 0);
    // R4 / R6 serial readback of all defaults
    for (int a = 0; a < 16; a++) begin
      rd_reg(a, r, o);
      chk(r == dflt(a), "R4 R6 read default", r, dflt(a));
      chk(o, "R4 enable window", o, 1);
    end
    // R1 / R6 write sweep over every address, checked twice
    for (int a = 0; a < 16; a++) begin
      wr_reg(a, pat(a, 1));
      rd_reg(a, r, o);
      chk(r == model[a], "R1 R6 write readback", r, model[a]);
      if (a < 11) chk(reg_of(a) == model[a], "R1 parallel", reg_of(a), model[a]);
    end
    // R2 reads left the bank untouched
    for (int a = 0; a < 11; a++) chk(reg_of(a) == model[a], "R2 no change", reg_of(a), model[a]);
    // R8 after a write to register 1
    wr_reg(1, 20'hABCDE);
    chk(n_count == 13'(20'hABCDE >> 7), "R8 n field", n_count, 20'hABCDE >> 7);
    chk(a_count == 7'(20'hABCDE), "R8 a field", a_count, 20'hABCDE & 7'h7F);
    // R5 short frame commits nothing
    frame(5, 1, 20'h13579, 24, 0, r, o);
    chk(reg_of(5) == model[5], "R5 short frame", reg_of(5), model[5]);
    // R5 long frame commits first 25 bits
    frame(6, 1, 20'h2468A, 27, 0, r, o);
    model[6] = 20'h2468A;
    chk(reg_of(6) == model[6], "R5 long frame", reg_of(6), model[6]);
    // R9 latch and clock rise together, then a fresh frame
    frame(3, 1, 20'h0F0F1, 25, 1, r, o);
    model[3] = 20'h0F0F1;
    chk(reg_of(3) == model[3], "R9 commit with clock", reg_of(3), model[3]);
    wr_reg(4, 20'hC3C3C);
    chk(reg_of(4) == model[4], "R9 next frame aligned", reg_of(4), model[4]);
    chk(reg_of(3) == model[3], "R9 prior kept", reg_of(3), model[3]);
    // R7 channel-code mode
    mode_sel = 0;
    cyc(4);
    for (int c = 0; c < 8; c++) begin
      {sclk, sle, sdio_in} = 3'(c);
      cyc(4);
      chk(chan_code == 3'(c), "R7 channel code", chan_code, c);
      chk(!sdio_oe, "R7 enable low", sdio_oe, 0);
    end
    {sclk, sle, sdio_in} = 3'b000;
    cyc(4);
    frame(2, 1, 20'h55555, 25, 0, r, o);
    frame(2, 0, 20'h0, 25, 0, r, o);
    chk(o == 0, "R7 no read drive", o, 0);
    mode_sel = 1;
    cyc(4);
    chk(reg_of(2) == model[2], "R7 frame ignored", reg_of(2), model[2]);
    rd_reg(2, r, o);
    chk(r == model[2], "R7 value intact", r, model[2]);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule